// File: doc/BRIEF.md
# Interrupt Priority Controller with Preemption

This block chooses which exception a processor core should run next. Interrupt request lines are level sensitive. Each line has an enable bit that is set by a write-one-to-set strobe and cleared by a write-one-to-clear strobe. Each line also has a 3-bit programmable priority, where a lower value is more urgent. A grouping field gives the number of low priority bits that form the subpriority. The remaining upper bits form the preemption part.

Two fixed exceptions rank above every programmable level. The reset exception is active when reset ends and stays active until the core signals its first handler exit. The hard fault exception is requested on its own input. The block keeps one active bit per exception, which lets it follow nesting. The running exception is the most urgent active one.

A request is taken only when it can preempt the current execution level. When it is taken, the block pulses an acknowledge with the exception number. In that same cycle it updates the active exception and the active level. When the core signals a handler exit and another request is already eligible, the block takes that request directly and flags a tail-chain.

Top module: `prio_ctrl`

## Requirements
- R1: After reset, all enable bits read 0, every priority field is 0, and the grouping field is 0. The reset exception is running: actValid=1, actId=0, actLevel=0, and takeValid=0.
- R2: A write with enSetWe sets the enable bits where enWrData is 1. A write with enClrWe clears those bits. When both strobes hit the same bit, clear wins. enRdData shows the enable vector one cycle after the write.
- R3: No request is taken unless its line is high and its enable bit is set. While the reset exception is running, nothing is taken.
- R4: Among eligible requests, the lowest 3-bit priority wins. Ties go to the lower line number. The exception number reported for line i is i+2; 0 is reset and 1 is hard fault.
- R5: The execution level of line i is 2 + (priority with its low grpWrData bits cleared). A request preempts only when its level is strictly below the running level.
- R6: A hard fault request runs at level 1. It preempts any programmable level, and no interrupt line preempts it.
- R7: A take produces a one-cycle takeValid pulse with takeId. In that same cycle, actId equals takeId and actLevel is the new level. preempt=1 when the take interrupted a running exception without a handler exit. With no exception active, actValid=0 and actLevel=15.
- R8: A handlerDone pulse retires the running exception. If an eligible request is below the remaining level, the next cycle shows a take with tailChain=1. Otherwise the previous exception resumes, or the core returns to thread level, with no take.
- R9: A line still high at handler exit is pending again and is re-taken through a tail-chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | N | Level-sensitive interrupt request lines |
| hardFaultReq | input | 1 | Hard fault request |
| handlerDone | input | 1 | Core exits the running handler (one-cycle pulse) |
| enSetWe | input | 1 | Write-one-to-set strobe for enable bits |
| enClrWe | input | 1 | Write-one-to-clear strobe for enable bits |
| enWrData | input | N | Data for enable writes |
| enRdData | output | N | Current enable vector |
| prioWe | input | 1 | Priority write strobe |
| prioIdx | input | $clog2(N) | Line whose priority is written |
| prioWrData | input | 3 | New priority value |
| grpWe | input | 1 | Grouping write strobe |
| grpWrData | input | 2 | Number of subpriority bits (0 to 3) |
| takeValid | output | 1 | Acknowledge pulse for a newly taken exception |
| takeId | output | $clog2(N+2) | Exception number taken |
| tailChain | output | 1 | The take came directly at handler exit |
| preempt | output | 1 | The take interrupted a running exception |
| actValid | output | 1 | Some exception is active |
| actId | output | $clog2(N+2) | Running exception number |
| actLevel | output | 4 | Running execution level, 15 at thread level |

## Verification
The hardest state to reach is an exit from a nested handler. The resumed level must come from the remaining active set, and it must be compared against requests that became pending while the inner handler ran. The bench gets there by building nesting on purpose. It takes a low-urgency line, preempts it with a more urgent line or a hard fault, and raises a third line during the inner handler. It then exits and checks whether the third line tail-chains or waits. The same scenario is repeated under two grouping settings, so that one priority pair preempts in one setting and does not in the other.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = 4;
  localparam logic [LVL_W-1:0] LVL_RST  = 4'd0;
  localparam logic [LVL_W-1:0] LVL_HF   = 4'd1;
  localparam logic [LVL_W-1:0] LVL_BASE = 4'd2;
  localparam logic [LVL_W-1:0] LVL_IDLE = 4'd15;

  typedef struct packed {
    logic retire;
    logic takeIrq;
    logic takeHf;
  } ctlStrobe_t;
endpackage

// File: rtl/prio_dp.sv
module prio_dp
  import prio_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int EW = $clog2(N + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      irqReq,
  input  logic              enSetWe,
  input  logic              enClrWe,
  input  logic [N-1:0]      enWrData,
  input  logic              prioWe,
  input  logic [IW-1:0]     prioIdx,
  input  logic [PRIO_W-1:0] prioWrData,
  input  logic              grpWe,
  input  logic [1:0]        grpWrData,
  input  ctlStrobe_t        strobe,
  output logic [N-1:0]      enRdData,
  output logic              bestValid,
  output logic [IW-1:0]     bestIdx,
  output logic [LVL_W-1:0]  bestLevel,
  output logic [LVL_W-1:0]  levelAfter,
  output logic              hfAfter,
  output logic              anyActive,
  output logic [EW-1:0]     runId,
  output logic [LVL_W-1:0]  runLevel
);
  logic [N-1:0]      enQ, actQ, actAfter, cand;
  logic [PRIO_W-1:0] prioQ [N];
  logic [1:0]        subQ;
  logic              rstActQ, hfActQ, rstAfter;
  logic [PRIO_W-1:0] grpMask;
  logic [LVL_W-1:0]  lvlOf [N];
  logic              runIrqValid;
  logic [IW-1:0]     runIrqIdx;
  logic [LVL_W-1:0]  runIrqLvl, minAfter;
  logic [LVL_W-1:0]  bestKey;
  logic              retireIrq;

  assign grpMask = {PRIO_W{1'b1}} << subQ;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign lvlOf[g] = LVL_BASE + LVL_W'(prioQ[g] & grpMask);
  end

  // running programmable exception: most urgent active line
  always_comb begin
    runIrqValid = 1'b0;
    runIrqIdx   = '0;
    runIrqLvl   = LVL_IDLE;
    for (int i = 0; i < N; i++) begin
      if (actQ[i] && lvlOf[i] < runIrqLvl) begin
        runIrqValid = 1'b1;
        runIrqIdx   = IW'(i);
        runIrqLvl   = lvlOf[i];
      end
    end
  end

  assign anyActive = rstActQ | hfActQ | runIrqValid;
  assign runId     = rstActQ ? EW'(0) : hfActQ ? EW'(1)
                   : runIrqValid ? EW'(runIrqIdx) + EW'(2) : EW'(0);
  assign runLevel  = rstActQ ? LVL_RST : hfActQ ? LVL_HF : runIrqLvl;

  // active set after the optional retire of the running exception
  assign retireIrq = strobe.retire & ~rstActQ & ~hfActQ;
  assign rstAfter  = rstActQ & ~strobe.retire;
  assign hfAfter   = hfActQ & ~(strobe.retire & ~rstActQ);
  assign actAfter  = actQ & ~(retireIrq ? (N'(1) << runIrqIdx) : '0);

  always_comb begin
    minAfter = LVL_IDLE;
    for (int i = 0; i < N; i++) begin
      if (actAfter[i] && lvlOf[i] < minAfter) minAfter = lvlOf[i];
    end
  end

  assign levelAfter = rstAfter ? LVL_RST : hfAfter ? LVL_HF : minAfter;

  // best eligible request: full priority, then lower index
  assign cand = irqReq & enQ & ~actAfter;

  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestKey   = 4'd8;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && {1'b0, prioQ[i]} < bestKey) begin
        bestValid = 1'b1;
        bestIdx   = IW'(i);
        bestKey   = {1'b0, prioQ[i]};
      end
    end
  end

  assign bestLevel = lvlOf[bestIdx];
  assign enRdData  = enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= '0;
      actQ    <= '0;
      subQ    <= '0;
      rstActQ <= 1'b1;
      hfActQ  <= 1'b0;
      for (int i = 0; i < N; i++) prioQ[i] <= '0;
    end else begin
      enQ <= (enQ | (enSetWe ? enWrData : '0)) & ~(enClrWe ? enWrData : '0);
      if (prioWe) prioQ[prioIdx] <= prioWrData;
      if (grpWe) subQ <= grpWrData;
      rstActQ <= rstAfter;
      hfActQ  <= hfAfter | strobe.takeHf;
      actQ    <= actAfter | (strobe.takeIrq ? (N'(1) << bestIdx) : '0);
    end
  end
endmodule

// File: rtl/prio_ctl.sv
module prio_ctl
  import prio_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int EW = $clog2(N + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             handlerDone,
  input  logic             hardFaultReq,
  input  logic             bestValid,
  input  logic [IW-1:0]    bestIdx,
  input  logic [LVL_W-1:0] bestLevel,
  input  logic [LVL_W-1:0] levelAfter,
  input  logic             hfAfter,
  input  logic             anyActive,
  output ctlStrobe_t       strobe,
  output logic             takeValid,
  output logic [EW-1:0]    takeId,
  output logic             tailChain,
  output logic             preempt
);
  logic take;

  always_comb begin
    strobe.retire  = handlerDone & anyActive;
    strobe.takeHf  = hardFaultReq & ~hfAfter & (levelAfter > LVL_HF);
    strobe.takeIrq = ~strobe.takeHf & bestValid & (bestLevel < levelAfter);
  end

  assign take = strobe.takeHf | strobe.takeIrq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeValid <= 1'b0;
      takeId    <= '0;
      tailChain <= 1'b0;
      preempt   <= 1'b0;
    end else begin
      takeValid <= take;
      takeId    <= strobe.takeHf ? EW'(1) : EW'(bestIdx) + EW'(2);
      tailChain <= take & strobe.retire;
      preempt   <= take & ~strobe.retire & anyActive;
    end
  end
endmodule

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int EW = $clog2(N + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      irqReq,
  input  logic              hardFaultReq,
  input  logic              handlerDone,
  input  logic              enSetWe,
  input  logic              enClrWe,
  input  logic [N-1:0]      enWrData,
  output logic [N-1:0]      enRdData,
  input  logic              prioWe,
  input  logic [IW-1:0]     prioIdx,
  input  logic [PRIO_W-1:0] prioWrData,
  input  logic              grpWe,
  input  logic [1:0]        grpWrData,
  output logic              takeValid,
  output logic [EW-1:0]     takeId,
  output logic              tailChain,
  output logic              preempt,
  output logic              actValid,
  output logic [EW-1:0]     actId,
  output logic [LVL_W-1:0]  actLevel
);
  ctlStrobe_t       strobe;
  logic             bestValid, hfAfter;
  logic [IW-1:0]    bestIdx;
  logic [LVL_W-1:0] bestLevel, levelAfter;

  prio_dp #(.N(N), .IW(IW), .EW(EW)) i_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq),
    .enSetWe(enSetWe), .enClrWe(enClrWe), .enWrData(enWrData),
    .prioWe(prioWe), .prioIdx(prioIdx), .prioWrData(prioWrData),
    .grpWe(grpWe), .grpWrData(grpWrData), .strobe(strobe),
    .enRdData(enRdData), .bestValid(bestValid), .bestIdx(bestIdx),
    .bestLevel(bestLevel), .levelAfter(levelAfter), .hfAfter(hfAfter),
    .anyActive(actValid), .runId(actId), .runLevel(actLevel)
  );

  prio_ctl #(.N(N), .IW(IW), .EW(EW)) i_ctl (
    .clk(clk), .rstN(rstN), .handlerDone(handlerDone),
    .hardFaultReq(hardFaultReq), .bestValid(bestValid), .bestIdx(bestIdx),
    .bestLevel(bestLevel), .levelAfter(levelAfter), .hfAfter(hfAfter),
    .anyActive(actValid), .strobe(strobe), .takeValid(takeValid),
    .takeId(takeId), .tailChain(tailChain), .preempt(preempt)
  );
endmodule

// File: rtl/prio_ctrl_chk.sv
module prio_ctrl_chk #(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int EW = $clog2(N + 2)
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  irqReq,
  input logic          handlerDone,
  input logic [N-1:0]  enRdData,
  input logic          takeValid,
  input logic [EW-1:0] takeId,
  input logic          tailChain,
  input logic          preempt,
  input logic          actValid,
  input logic [EW-1:0] actId,
  input logic [3:0]    actLevel
);
  logic [N-1:0]  reqEnPast;
  logic [IW-1:0] takeIdx;

  always_ff @(posedge clk) reqEnPast <= irqReq & enRdData;
  assign takeIdx = IW'(takeId - EW'(2));

  AST_TAKE_UPDATES_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> (actValid && actId == takeId));  // R7
  AST_TAIL_NEEDS_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    tailChain |-> $past(handlerDone));  // R8
  AST_TAIL_IS_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    tailChain |-> takeValid);  // R8
  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rstN)
    preempt |-> (actLevel < $past(actLevel)));  // R5
  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && takeId >= EW'(2)) |-> reqEnPast[takeIdx]);  // R3
  AST_RESET_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && actId == '0) |-> !takeValid);  // R3
  AST_HF_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && actId == EW'(1)) |-> actLevel == 4'd1);  // R6
endmodule

bind prio_ctrl prio_ctrl_chk #(.N(N), .IW(IW), .EW(EW)) i_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .handlerDone(handlerDone),
  .enRdData(enRdData), .takeValid(takeValid), .takeId(takeId),
  .tailChain(tailChain), .preempt(preempt), .actValid(actValid),
  .actId(actId), .actLevel(actLevel)
);

// File: tb/test_prio_ctrl.sv
module test_prio_ctrl;
  localparam int N = 8;
  localparam int IW = $clog2(N);
  localparam int EW = $clog2(N + 2);
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] irqReq = '0, enWrData = '0, enRdData;
  logic hardFaultReq = 0, handlerDone = 0, enSetWe = 0, enClrWe = 0;
  logic prioWe = 0, grpWe = 0;
  logic [IW-1:0] prioIdx = '0;
  logic [2:0] prioWrData = '0;
  logic [1:0] grpWrData = '0;
  logic takeValid, tailChain, preempt, actValid;
  logic [EW-1:0] takeId, actId;
  logic [3:0] actLevel;
  int nRun = 0, nFail = 0;

  prio_ctrl #(.N(N)) i_prio_ctrl (.*);

  always #(PERIOD / 2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkTake(input string req, input int id, input int lvl, input int tail, input int pre);
    chk(req, "takeValid", int'(takeValid), 1);
    chk(req, "takeId", int'(takeId), id);
    chk(req, "actId", int'(actId), id);
    chk(req, "actLevel", int'(actLevel), lvl);
    chk(req, "tailChain", int'(tailChain), tail);
    chk(req, "preempt", int'(preempt), pre);
  endtask

  task automatic chkIdle(input string req, input int id, input int lvl);
    chk(req, "takeValid idle", int'(takeValid), 0);
    chk(req, "actValid", int'(actValid), lvl == 15 ? 0 : 1);
    if (lvl != 15) chk(req, "actId", int'(actId), id);
    chk(req, "actLevel", int'(actLevel), lvl);
  endtask

  task automatic exitHandler();
    handlerDone = 1;
    step();
    handlerDone = 0;
  endtask

  task automatic setPrio(input int idx, input int val);
    prioWe = 1; prioIdx = IW'(idx); prioWrData = 3'(val);
    step();
    prioWe = 0;
  endtask

  task automatic setGrp(input int v);
    grpWe = 1; grpWrData = 2'(v);
    step();
    grpWe = 0;
  endtask

  task automatic writeEn(input logic s, input logic c, input logic [N-1:0] d);
    enSetWe = s; enClrWe = c; enWrData = d;
    step();
    enSetWe = 0; enClrWe = 0;
  endtask

  task automatic testReset();
    chkIdle("R1", 0, 0);
    chk("R1", "enRdData", int'(enRdData), 0);
    writeEn(1, 0, 8'hFF);
    irqReq = 8'h01;
    step();
    chkIdle("R3", 0, 0);
    exitHandler();
    chkTake("R8", 2, 2, 1, 0);
    irqReq = '0;
    exitHandler();
    chkIdle("R8", 0, 15);
  endtask

  task automatic testEnable();
    writeEn(0, 1, 8'hFF);
    chk("R2", "clear all", int'(enRdData), 0);
    writeEn(1, 0, 8'h0F);
    chk("R2", "set", int'(enRdData), 'h0F);
    writeEn(0, 1, 8'h05);
    chk("R2", "clear", int'(enRdData), 'h0A);
    writeEn(1, 1, 8'h30);
    chk("R2", "clear wins", int'(enRdData), 'h0A);
    irqReq = 8'h80;
    step();
    step();
    chkIdle("R3", 0, 15);
    irqReq = '0;
  endtask

  task automatic testOrder();
    writeEn(1, 0, 8'hFF);
    setPrio(2, 5); setPrio(5, 3); setPrio(6, 3);
    irqReq = 8'h64;
    step();
    chkTake("R4", 7, 5, 0, 0);
    step();
    chkIdle("R5", 7, 5);
    irqReq = 8'h44;
    exitHandler();
    chkTake("R8", 8, 5, 1, 0);
    irqReq = 8'h04;
    exitHandler();
    chkTake("R4", 4, 7, 1, 0);
    irqReq = '0;
    exitHandler();
    chkIdle("R8", 0, 15);
  endtask

  task automatic testGroup();
    setGrp(1);
    setPrio(0, 3); setPrio(1, 2); setPrio(3, 1);
    irqReq = 8'h01;
    step();
    chkTake("R5", 2, 4, 0, 0);
    irqReq = 8'h03;
    step();
    chkIdle("R5", 2, 4);
    irqReq = 8'h0B;
    step();
    chkTake("R5", 5, 2, 0, 1);
    irqReq = 8'h03;
    exitHandler();
    chkIdle("R8", 2, 4);
    irqReq = 8'h02;
    exitHandler();
    chkTake("R8", 3, 4, 1, 0);
    irqReq = '0;
    exitHandler();
    chkIdle("R8", 0, 15);
    setGrp(0);
    irqReq = 8'h01;
    step();
    chkTake("R5", 2, 5, 0, 0);
    irqReq = 8'h03;
    step();
    chkTake("R7", 3, 4, 0, 1);
    irqReq = 8'h01;
    exitHandler();
    chkIdle("R8", 2, 5);
    irqReq = '0;
    exitHandler();
    chkIdle("R7", 0, 15);
  endtask

  task automatic testHardFault();
    setPrio(3, 1); setPrio(4, 0);
    irqReq = 8'h08;
    step();
    chkTake("R7", 5, 3, 0, 0);
    hardFaultReq = 1;
    step();
    hardFaultReq = 0;
    chkTake("R6", 1, 1, 0, 1);
    irqReq = 8'h18;
    step();
    chkIdle("R6", 1, 1);
    exitHandler();
    chkTake("R8", 6, 2, 1, 0);
    irqReq = 8'h08;
    exitHandler();
    chkIdle("R8", 5, 3);
    irqReq = '0;
    exitHandler();
    chkIdle("R8", 0, 15);
  endtask

  task automatic testLevel();
    irqReq = 8'h80;
    step();
    chkTake("R9", 9, 2, 0, 0);
    exitHandler();
    chkTake("R9", 9, 2, 1, 0);
    irqReq = '0;
    exitHandler();
    chkIdle("R9", 0, 15);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    testReset();
    testEnable();
    testOrder();
    testGroup();
    testHardFault();
    testLevel();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule